// File: doc/BRIEF.md
# Integer ALU with Condition Flags and Branch Decision

This block is the arithmetic stage of a small 32-bit processor. Each cycle it combines two register operands under a 2-bit operation code, which selects add, subtract, bitwise AND or bitwise XOR. The result leaves the block combinationally, so the surrounding datapath can write it back in the same cycle.

The block also keeps three condition flags: zero, negative and signed overflow. The flags are loaded from the current operation only on a clock edge where the flag-load input is high. Moves and other non-arithmetic instructions leave that input low, so they keep the flags unchanged.

A branch evaluator reads the stored flags together with a 4-bit branch code and produces a taken decision for a conditional jump. Operand fetch and result writeback are handled outside the block.

Top module: `alu_cc_unit`

## Requirements
- R1: With op code 0 the result equals (opnd_b + opnd_a) modulo 2^32.
- R2: With op code 1 the result equals (opnd_b - opnd_a) modulo 2^32, so the first operand is subtracted from the second.
- R3: With op code 2 the result is the bitwise AND of the operands, and with op code 3 it is their bitwise XOR.
- R4: On a flag load, the zero flag becomes 1 exactly when the result is all zeros, and the negative flag takes the result's bit 31.
- R5: On a flag load, the overflow flag behaves as follows. For add it is set when both operands have the same sign and the result's sign differs. For subtract it is set when the true signed value of opnd_b - opnd_a lies outside the 32-bit signed range. For AND and XOR it is cleared.
- R6: The flags change only on a rising clock edge where set_flags is 1. On every other edge they keep their value.
- R7: After reset the flags are zero=1, negative=0, overflow=0.
- R8: With N = negative xor overflow, taken_o is defined for each branch code as follows:
  - 0: 1
  - 1: N or zero
  - 2: N
  - 3: zero
  - 4: not zero
  - 5: not N
  - 6: not N and not zero
  - 7 to 15: 0
- R9: taken_o is computed from the stored flags. A flag load requested in the same cycle affects taken_o only after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 32 | First operand (the subtrahend for subtract) |
| opnd_b | input | 32 | Second operand |
| op_code | input | 2 | 0 add, 1 subtract, 2 AND, 3 XOR |
| set_flags | input | 1 | Load the flags from this cycle's operation at the next edge |
| br_code | input | 4 | Branch condition selector |
| result_o | output | 32 | Operation result (combinational) |
| flag_of_o | output | 1 | Stored signed overflow flag |
| flag_zf_o | output | 1 | Stored zero flag |
| flag_sf_o | output | 1 | Stored negative flag |
| taken_o | output | 1 | Branch decision from the stored flags |

## Verification
The flag register is the block's only state. A wrong flag therefore shows up one edge after a load, both on the flag outputs and on any branch code that depends on that flag. The result path has no state, so an arithmetic error appears in the same cycle the operands are applied. A spurious load on an edge where set_flags is low shows up at once, because the bench alternates loads with held cycles whose operations would produce different flags.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    BR_ALWAYS = 4'd0,
    BR_LE     = 4'd1,
    BR_LT     = 4'd2,
    BR_EQ     = 4'd3,
    BR_NE     = 4'd4,
    BR_GE     = 4'd5,
    BR_GT     = 4'd6
  } br_e;

  typedef struct packed {
    logic of;
    logic zf;
    logic sf;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{of: 1'b0, zf: 1'b1, sf: 1'b0};

  // Branch decision from a flag set; undefined codes never branch.
  function automatic logic branch_decide(input logic [3:0] code, input flags_t f);
    logic lt;
    lt = f.sf ^ f.of;
    case (code)
      BR_ALWAYS: branch_decide = 1'b1;
      BR_LE:     branch_decide = lt | f.zf;
      BR_LT:     branch_decide = lt;
      BR_EQ:     branch_decide = f.zf;
      BR_NE:     branch_decide = ~f.zf;
      BR_GE:     branch_decide = ~lt;
      BR_GT:     branch_decide = ~lt & ~f.zf;
      default:   branch_decide = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       op,
  output logic [WIDTH-1:0] res,
  output flags_t           nxt_flags
);
  localparam int MSB = WIDTH - 1;

  // Shared adder: subtract is b + ~a + 1.
  function automatic logic [WIDTH-1:0] add_sub(input logic [WIDTH-1:0] x,
                                               input logic [WIDTH-1:0] y,
                                               input logic do_sub);
    logic [WIDTH-1:0] y_eff;
    y_eff = do_sub ? ~x : x;
    add_sub = y + y_eff + {{(WIDTH-1){1'b0}}, do_sub};
  endfunction

  function automatic logic ovf_rule(input logic [1:0] o, input logic sa,
                                    input logic sb, input logic sr);
    case (o)
      OP_ADD:  ovf_rule = (sa == sb) && (sr != sb);
      OP_SUB:  ovf_rule = (sa != sb) && (sr != sb);
      default: ovf_rule = 1'b0;
    endcase
  endfunction

  logic [WIDTH-1:0] arith_res;
  logic             is_logic_op;

  assign arith_res   = add_sub(a, b, op == OP_SUB);
  assign is_logic_op = (op == OP_AND) || (op == OP_XOR);

  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      default: res = arith_res;
    endcase
  end

  assign nxt_flags.of = ovf_rule(op, a[MSB], b[MSB], res[MSB]);
  assign nxt_flags.zf = (res == '0);
  assign nxt_flags.sf = res[MSB];

  // R5: logical operations never report overflow
  always_comb begin
    p_logic_of_clear_r5: assert (!(is_logic_op && nxt_flags.of));
  end

endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import alu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= FLAGS_RESET;
    else if (load) q <= d;
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));

endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import alu_pkg::*;
(
  input  logic [3:0] code,
  input  flags_t     flags,
  output logic       taken
);
  assign taken = branch_decide(code, flags);

  // R8: codes above the defined set never branch; code 0 always does
  always_comb begin
    p_undef_code_r8: assert (!(code > 4'd6 && taken));
    p_always_r8:     assert (!(code == 4'd0 && !taken));
  end

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [1:0]       op_code,
  input  logic             set_flags,
  input  logic [3:0]       br_code,
  output logic [WIDTH-1:0] result_o,
  output logic             flag_of_o,
  output logic             flag_zf_o,
  output logic             flag_sf_o,
  output logic             taken_o
);
  flags_t nxt_flags;
  flags_t cur_flags;

  alu_core #(.WIDTH(WIDTH)) u_core (
    .a         (opnd_a),
    .b         (opnd_b),
    .op        (op_code),
    .res       (result_o),
    .nxt_flags (nxt_flags)
  );

  flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (set_flags),
    .d     (nxt_flags),
    .q     (cur_flags)
  );

  branch_eval u_branch (
    .code  (br_code),
    .flags (cur_flags),
    .taken (taken_o)
  );

  assign flag_of_o = cur_flags.of;
  assign flag_zf_o = cur_flags.zf;
  assign flag_sf_o = cur_flags.sf;

  // R4: stored zero and sign flags track the result seen at the load
  p_zero_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> (flag_zf_o == ($past(result_o) == '0)));

  p_sign_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> (flag_sf_o == $past(result_o[WIDTH-1])));

endmodule

// File: tb/tb_alu_cc_unit.sv
module tb_alu_cc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [1:0]  op_code = '0;
  logic        set_flags = 1'b0;
  logic [3:0]  br_code = '0;
  logic [31:0] result_o;
  logic        flag_of_o, flag_zf_o, flag_sf_o, taken_o;

  alu_cc_unit dut (.*);

  always #10 clk = ~clk; // 50 MHz

  typedef struct {
    int          kind;   // 0 result, 1 flags {of,zf,sf}, 2 taken
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  event  sample_ev;
  int    n_checks = 0, n_errors = 0;
  bit    finished = 0;

  // bench model of stored flags
  logic m_of = 0, m_zf = 1, m_sf = 0;

  // monitor: pops expectations and compares against the ports
  initial forever begin
    @(sample_ev);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = q.pop_front();
      case (it.kind)
        0:       got = result_o;
        1:       got = {29'd0, flag_of_o, flag_zf_o, flag_sf_o};
        default: got = {31'd0, taken_o};
      endcase
      n_checks++;
      if (got !== it.exp) begin
        n_errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
      end
    end
  end

  function automatic logic exp_taken(input logic [3:0] c);
    logic n;
    n = m_sf ^ m_of;
    if (c == 0) return 1;
    if (c == 1) return n || m_zf;
    if (c == 2) return n;
    if (c == 3) return m_zf;
    if (c == 4) return !m_zf;
    if (c == 5) return !n;
    if (c == 6) return !n && !m_zf;
    return 0;
  endfunction

  task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                      input logic ld, input logic [3:0] bc);
    logic [31:0] r;
    logic signed [33:0] wide;
    logic ov;
    string rq;
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_code = op; set_flags = ld; br_code = bc;
    wide = '0;
    case (op)
      2'd0: begin r = b + a; rq = "R1";
                  wide = $signed({{2{b[31]}}, b}) + $signed({{2{a[31]}}, a}); end
      2'd1: begin r = b - a; rq = "R2";
                  wide = $signed({{2{b[31]}}, b}) - $signed({{2{a[31]}}, a}); end
      2'd2: begin r = a & b; rq = "R3"; end
      default: begin r = a ^ b; rq = "R3"; end
    endcase
    ov = (op < 2) ? (wide > 34'sh0_7FFF_FFFF || wide < -34'sh0_8000_0000) : 1'b0;
    q.push_back('{0, r, rq});
    q.push_back('{1, {29'd0, m_of, m_zf, m_sf}, "R6"});
    q.push_back('{2, {31'd0, exp_taken(bc)}, ld ? "R9" : "R8"});
    ->sample_ev;
    #3;
    @(posedge clk);
    if (ld) begin
      m_of = ov; m_zf = (r == 0); m_sf = r[31];
    end
    // flags after load checked with R4/R5 tag at next negedge
    @(negedge clk);
    q.push_back('{1, {29'd0, m_of, m_zf, m_sf}, ld ? "R4_R5" : "R6"});
    ->sample_ev;
    #3;
  endtask

  task automatic sweep_branches();
    for (int c = 0; c < 16; c++) step(32'd1, 32'd2, 2'd2, 1'b0, c[3:0]);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #45;
    // R7: reset values
    n_checks++;
    if ({flag_of_o, flag_zf_o, flag_sf_o} !== 3'b010) begin
      n_errors++;
      $display("FAIL R7 actual=%b expected=010", {flag_of_o, flag_zf_o, flag_sf_o});
    end
    rst_n = 1'b1;
    sweep_branches();                                         // R8 with zf=1
    step(32'h7FFF_FFFF, 32'h0000_0001, 2'd0, 1'b1, 4'd3);     // R1/R5 add overflow, R9
    sweep_branches();                                         // sf=1 of=1
    step(32'h0000_0005, 32'h0000_0003, 2'd1, 1'b1, 4'd2);     // R2 negative
    sweep_branches();
    step(32'h1234_5678, 32'h1234_5678, 2'd1, 1'b1, 4'd4);     // zero
    step(32'h0000_0001, 32'h8000_0000, 2'd1, 1'b1, 4'd0);     // R5 sub overflow
    sweep_branches();
    step(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 1'b0, 4'd1);     // R6 hold, XOR zero
    step(32'hF0F0_F0F0, 32'hFF00_FF00, 2'd2, 1'b1, 4'd5);     // R3 AND, R5 clear
    sweep_branches();
    step(32'h0000_0010, 32'h0000_0020, 2'd0, 1'b1, 4'd6);     // positive
    sweep_branches();
    step(32'h8000_0000, 32'h8000_0000, 2'd0, 1'b0, 4'd3);     // R6 hold
    step(32'hA5A5_A5A5, 32'h5A5A_5A5A, 2'd3, 1'b1, 4'd2);     // R3 XOR
    step(32'h8000_0000, 32'h8000_0000, 2'd0, 1'b1, 4'd3);     // add wrap to zero, overflow
    sweep_branches();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule